// File: doc/BRIEF.md
# Slot-Based Program Bank Mapper

This block sits between a processor with a 16-bit address bus and two external byte-wide memories, one read-only (program ROM) and one read/write (work RAM). The address space is cut into sixteen 4 KB slots. Each slot holds a bank index and a flag that says whether the slot shows ROM or RAM. A processor access is turned into a physical memory address and read or write strobes without any added latency. The read data seen by the processor is selected combinationally.

A controller reconfigures the map through a one-cycle command port. One command switches a bank of 4, 8, 16 or 32 KB into a run of consecutive slots, and the larger sizes expand into consecutive 4 KB sub-bank indices. Another command sets the RAM/ROM flag over a run of slots. Four more commands set the per-bank RAM enable and write-permit bits, either for one bank or for every bank at once. A disabled RAM bank reads as zero, and writes reach RAM only when the target bank is both enabled and writable.

The command decoder classifies each command with a unique case over an enumerated opcode type. The opcodes are NOP, MAP, KIND, EN_ALL, WR_ALL, EN_ONE and WR_ONE. There is no multi-cycle sequencing: every command completes at the clock edge on which it is presented.

Top module: `prg_bank_mapper`

## Requirements
- R1: The slot is chosen by `cpu_addr[15:12]`, and `cpu_addr[11:0]` appears unchanged as the low 12 bits of both `rom_addr` and `ram_addr`.
- R2: A read of a slot flagged ROM raises `rom_rd` and never `ram_rd`. It drives `rom_addr = {bank, offset}` and returns `rom_data` on `cpu_rdata`.
- R3: The stored index is reduced to its low log2(bank count) bits of the memory the slot selects: ROM_BANKS for a ROM slot, RAM_BANKS for a RAM slot.
- R4: Opcode 3'd1 (MAP) with `cmd_size` s (0=4 KB, 1=8 KB, 2=16 KB, 3=32 KB) sets N=2^s. It writes index·N+k into slot `cmd_slot`+k for k=0..N−1, truncated to IDX_W bits.
- R5: A MAP or KIND run that would pass slot 15 writes only the slots up to 15 and leaves slots 0 upward untouched.
- R6: Opcode 3'd2 (KIND) sets the RAM flag to `cmd_flag` (1=RAM) over the same run of slots that `cmd_size` and `cmd_slot` define for MAP.
- R7: A read of a RAM slot whose bank is disabled returns 8'h00 and raises neither `ram_rd` nor `rom_rd`. An enabled RAM bank raises `ram_rd` and returns `ram_rdata`.
- R8: `ram_wr` is raised only for a write to a RAM slot whose bank is enabled and writable. `ram_wdata` equals `cpu_wdata`, and writes to ROM slots are dropped.
- R9: Opcode 3'd3 sets every RAM bank's enable bit to `cmd_flag`, and opcode 3'd4 sets every bank's write-permit bit to `cmd_flag`.
- R10: Opcode 3'd5 sets the enable bit, and opcode 3'd6 the write-permit bit, of the single RAM bank `cmd_index` mod RAM_BANKS. Opcodes 3'd0 and 3'd7 change nothing.
- R11: After reset, slots 4–7 show RAM with indices 0–3, and slots 8–15 show ROM with indices 0–7. Slots 0–3 show ROM index 0, and every RAM bank is enabled and writable.
- R12: A command changes the map at the clock edge that samples it. An access in the same cycle still uses the old map, because the translation is combinational from the slot registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | log2(ROM_BANKS)+12 | Physical ROM byte address |
| rom_rd | output | 1 | ROM read strobe |
| rom_data | input | 8 | ROM read data |
| ram_addr | output | log2(RAM_BANKS)+12 | Physical RAM byte address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_size | input | 2 | Run size for MAP/KIND (4/8/16/32 KB) |
| cmd_slot | input | 4 | First slot of the run |
| cmd_index | input | IDX_W | Bank index (MAP) or RAM bank number (EN_ONE/WR_ONE) |
| cmd_flag | input | 1 | RAM flag or enable/permit value |

## Verification
The bench builds the mapper with ROM_BANKS=16, RAM_BANKS=4 and IDX_W=8. With these values, random 8-bit indices often exceed both bank counts, so the masking of the same stored index two different ways is exercised constantly. Four RAM banks are few enough that random enable and write-permit commands regularly leave the bank under access disabled or protected. Random MAP and KIND runs at random start slots frequently run past slot 15, which puts the truncation at the top of the map within reach alongside the directed cases.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam int SLOTS  = 16;
    localparam int SLOT_W = 4;
    localparam int OFF_W  = 12;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_MAP    = 3'd1,
        OP_KIND   = 3'd2,
        OP_EN_ALL = 3'd3,
        OP_WR_ALL = 3'd4,
        OP_EN_ONE = 3'd5,
        OP_WR_ONE = 3'd6,
        OP_RSVD   = 3'd7
    } pbm_op_e;
endpackage

// File: rtl/pbm_slot_table.sv
module pbm_slot_table
    import pbm_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        map_we,
    input  logic                        kind_we,
    input  logic [SLOT_W-1:0]           base_slot,
    input  logic [1:0]                  run_size,
    input  logic [IDX_W-1:0]            run_index,
    input  logic                        run_flag,
    output logic [SLOTS-1:0][IDX_W-1:0] slot_idx,
    output logic [SLOTS-1:0]            slot_ram
);
    logic [SLOT_W:0] run_len;
    assign run_len = (SLOT_W+1)'(1) << run_size;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [SLOT_W:0] rel;
        logic            hit;
        logic [IDX_W-1:0] new_idx;

        // rel wraps past the run length when s is below the base slot
        assign rel     = (SLOT_W+1)'(s) - {1'b0, base_slot};
        assign hit     = (rel < run_len);
        assign new_idx = IDX_W'(run_index << run_size) + IDX_W'(rel);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                if (s >= 4 && s < 8) begin
                    slot_ram[s] <= 1'b1;
                    slot_idx[s] <= IDX_W'(s - 4);
                end else if (s >= 8) begin
                    slot_ram[s] <= 1'b0;
                    slot_idx[s] <= IDX_W'(s - 8);
                end else begin
                    slot_ram[s] <= 1'b0;
                    slot_idx[s] <= '0;
                end
            end else if (hit) begin
                if (map_we)  slot_idx[s] <= new_idx;
                if (kind_we) slot_ram[s] <= run_flag;
            end
        end
    end
endmodule

// File: rtl/pbm_ram_guard.sv
module pbm_ram_guard #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_all_we,
    input  logic              wr_all_we,
    input  logic              en_one_we,
    input  logic              wr_one_we,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              value,
    output logic [BANKS-1:0]  bank_en,
    output logic [BANKS-1:0]  bank_wr
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic picked;
        assign picked = (bank_sel == BANK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_en[b] <= 1'b1;
                bank_wr[b] <= 1'b1;
            end else begin
                if (en_all_we || (en_one_we && picked)) bank_en[b] <= value;
                if (wr_all_we || (wr_one_we && picked)) bank_wr[b] <= value;
            end
        end
    end
endmodule

// File: rtl/pbm_xlate.sv
module pbm_xlate
    import pbm_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int ROM_BW    = 5,
    parameter int RAM_BW    = 2,
    parameter int RAM_BANKS = 4
) (
    input  logic [15:0]                 cpu_addr,
    input  logic                        cpu_rd,
    input  logic                        cpu_wr,
    input  logic [SLOTS-1:0][IDX_W-1:0] slot_idx,
    input  logic [SLOTS-1:0]            slot_ram,
    input  logic [RAM_BANKS-1:0]        bank_en,
    input  logic [RAM_BANKS-1:0]        bank_wr,
    input  logic [7:0]                  rom_data,
    input  logic [7:0]                  ram_rdata,
    output logic [ROM_BW+OFF_W-1:0]     rom_addr,
    output logic [RAM_BW+OFF_W-1:0]     ram_addr,
    output logic                        rom_rd,
    output logic                        ram_rd,
    output logic                        ram_wr,
    output logic [7:0]                  cpu_rdata
);
    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  offset;
    logic [IDX_W-1:0]  idx;
    logic [RAM_BW-1:0] rbank;
    logic              is_ram;
    logic              live;

    assign slot     = cpu_addr[15:12];
    assign offset   = cpu_addr[OFF_W-1:0];
    assign idx      = slot_idx[slot];
    assign is_ram   = slot_ram[slot];
    assign rbank    = idx[RAM_BW-1:0];
    assign live     = bank_en[rbank];

    assign rom_addr = {idx[ROM_BW-1:0], offset};
    assign ram_addr = {rbank, offset};
    assign rom_rd   = cpu_rd & ~is_ram;
    assign ram_rd   = cpu_rd & is_ram & live;
    assign ram_wr   = cpu_wr & is_ram & live & bank_wr[rbank];

    always_comb begin
        if (!is_ram)   cpu_rdata = rom_data;
        else if (live) cpu_rdata = ram_rdata;
        else           cpu_rdata = 8'h00;
    end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import pbm_pkg::*;
#(
    parameter int ROM_BANKS = 32,
    parameter int RAM_BANKS = 4,
    parameter int IDX_W     = 8,
    localparam int ROM_BW   = $clog2(ROM_BANKS),
    localparam int RAM_BW   = $clog2(RAM_BANKS),
    localparam int ROM_AW   = ROM_BW + OFF_W,
    localparam int RAM_AW   = RAM_BW + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [7:0]        rom_data,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_size,
    input  logic [3:0]        cmd_slot,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic              cmd_flag
);
    pbm_op_e op;
    logic    map_we, kind_we, en_all_we, wr_all_we, en_one_we, wr_one_we;

    logic [SLOTS-1:0][IDX_W-1:0] slot_idx;
    logic [SLOTS-1:0]            slot_ram;
    logic [RAM_BANKS-1:0]        bank_en;
    logic [RAM_BANKS-1:0]        bank_wr;

    assign op = pbm_op_e'(cmd_op);

    always_comb begin
        map_we    = 1'b0;
        kind_we   = 1'b0;
        en_all_we = 1'b0;
        wr_all_we = 1'b0;
        en_one_we = 1'b0;
        wr_one_we = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_MAP:    map_we    = 1'b1;
                OP_KIND:   kind_we   = 1'b1;
                OP_EN_ALL: en_all_we = 1'b1;
                OP_WR_ALL: wr_all_we = 1'b1;
                OP_EN_ONE: en_one_we = 1'b1;
                OP_WR_ONE: wr_one_we = 1'b1;
                default:   ;
            endcase
        end
    end

    pbm_slot_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (map_we),
        .kind_we   (kind_we),
        .base_slot (cmd_slot),
        .run_size  (cmd_size),
        .run_index (cmd_index),
        .run_flag  (cmd_flag),
        .slot_idx  (slot_idx),
        .slot_ram  (slot_ram)
    );

    pbm_ram_guard #(.BANKS(RAM_BANKS), .BANK_W(RAM_BW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_all_we (en_all_we),
        .wr_all_we (wr_all_we),
        .en_one_we (en_one_we),
        .wr_one_we (wr_one_we),
        .bank_sel  (cmd_index[RAM_BW-1:0]),
        .value     (cmd_flag),
        .bank_en   (bank_en),
        .bank_wr   (bank_wr)
    );

    pbm_xlate #(
        .IDX_W     (IDX_W),
        .ROM_BW    (ROM_BW),
        .RAM_BW    (RAM_BW),
        .RAM_BANKS (RAM_BANKS)
    ) u_xlate (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .slot_idx  (slot_idx),
        .slot_ram  (slot_ram),
        .bank_en   (bank_en),
        .bank_wr   (bank_wr),
        .rom_data  (rom_data),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .rom_rd    (rom_rd),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .cpu_rdata (cpu_rdata)
    );

    assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int RAM_BANKS = 4,
    parameter int IDX_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           cpu_addr,
    input logic                  cpu_rd,
    input logic                  cpu_wr,
    input logic [7:0]            cpu_wdata,
    input logic [7:0]            cpu_rdata,
    input logic [7:0]            rom_data,
    input logic                  rom_rd,
    input logic                  ram_rd,
    input logic                  ram_wr,
    input logic [7:0]            ram_wdata,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic [1:0]            cmd_size,
    input logic [3:0]            cmd_slot,
    input logic [IDX_W-1:0]      cmd_index,
    input logic                  cmd_flag,
    input logic [15:0][IDX_W-1:0] slot_idx,
    input logic [15:0]           slot_ram,
    input logic [RAM_BANKS-1:0]  bank_en,
    input logic [RAM_BANKS-1:0]  bank_wr
);
    logic cur_ram;
    assign cur_ram = slot_ram[cpu_addr[15:12]];

    a_r2_rom_path: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> (!ram_rd && !cur_ram && cpu_rdata == rom_data));

    a_r4_map_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && cmd_size == 2'd0)
        |=> slot_idx[$past(cmd_slot)] == $past(cmd_index));

    a_r7_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cur_ram && !ram_rd) |-> (cpu_rdata == 8'h00 && !rom_rd));

    a_r8_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (cpu_wr && cur_ram && ram_wdata == cpu_wdata));

    a_r9_enable_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3)
        |=> bank_en == {RAM_BANKS{$past(cmd_flag)}});

    a_r10_nop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd7))
        |=> ($stable(slot_idx) && $stable(slot_ram) && $stable(bank_en) && $stable(bank_wr)));
endmodule

bind prg_bank_mapper pbm_checker #(.RAM_BANKS(RAM_BANKS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .rom_data  (rom_data),
    .rom_rd    (rom_rd),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .ram_wdata (ram_wdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_size  (cmd_size),
    .cmd_slot  (cmd_slot),
    .cmd_index (cmd_index),
    .cmd_flag  (cmd_flag),
    .slot_idx  (slot_idx),
    .slot_ram  (slot_ram),
    .bank_en   (bank_en),
    .bank_wr   (bank_wr)
);

// File: tb/prg_bank_mapper_test.sv
`timescale 1ns/1ps
module prg_bank_mapper_test;
    localparam int ROM_BANKS = 16;
    localparam int RAM_BANKS = 4;
    localparam int IDX_W     = 8;
    localparam int ROM_AW    = 16;
    localparam int RAM_AW    = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic              cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        cpu_rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_rd;
    logic [7:0]        rom_data;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_rd, ram_wr;
    logic [7:0]        ram_wdata, ram_rdata;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [1:0]        cmd_size = '0;
    logic [3:0]        cmd_slot = '0;
    logic [IDX_W-1:0]  cmd_index = '0;
    logic              cmd_flag = 1'b0;

    int  tests = 0, fails = 0;
    bit  done = 0;

    logic [7:0] ram_mem [0:16383];
    logic [7:0] exp_ram [0:16383];
    logic [7:0] m_idx [0:15];
    bit         m_ram [0:15];
    bit         m_en  [0:3];
    bit         m_wr  [0:3];

    always #4 clk = ~clk;

    prg_bank_mapper #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rd(rom_rd),
        .rom_data(rom_data), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_size(cmd_size), .cmd_slot(cmd_slot), .cmd_index(cmd_index), .cmd_flag(cmd_flag)
    );

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[15:12], a[11:8]} ^ 8'h3C;
    endfunction

    assign rom_data  = rom_byte(rom_addr);
    assign ram_rdata = ram_mem[ram_addr];

    always @(posedge clk) if (ram_wr) ram_mem[ram_addr] <= ram_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 16; s++) begin
            m_ram[s] = (s >= 4 && s < 8);
            m_idx[s] = (s >= 8) ? 8'(s - 8) : (s >= 4 ? 8'(s - 4) : 8'd0);
        end
        for (int b = 0; b < 4; b++) begin m_en[b] = 1; m_wr[b] = 1; end
    endtask

    task automatic model_cmd(input logic [2:0] op, input logic [1:0] sz, input logic [3:0] sl,
                             input logic [7:0] ix, input bit fl);
        int n;
        n = 1 << sz;
        case (op)
            3'd1: for (int k = 0; k < n; k++) if (sl + k < 16) m_idx[sl + k] = 8'((ix * n) + k);
            3'd2: for (int k = 0; k < n; k++) if (sl + k < 16) m_ram[sl + k] = fl;
            3'd3: for (int b = 0; b < 4; b++) m_en[b] = fl;
            3'd4: for (int b = 0; b < 4; b++) m_wr[b] = fl;
            3'd5: m_en[ix[1:0]] = fl;
            3'd6: m_wr[ix[1:0]] = fl;
            default: ;
        endcase
    endtask

    task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic [3:0] sl,
                        input logic [7:0] ix, input bit fl);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_size = sz; cmd_slot = sl; cmd_index = ix; cmd_flag = fl;
        @(negedge clk);
        cmd_valid = 0;
        model_cmd(op, sz, sl, ix, fl);
    endtask

    // read check, R1/R2/R3/R7 from the model
    task automatic rd_check(input logic [15:0] a, input string req);
        int s; logic [1:0] b; logic [13:0] ra;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1; cpu_wr = 0;
        #1;
        s = a[15:12];
        if (m_ram[s]) begin
            b  = m_idx[s][1:0];
            ra = {b, a[11:0]};
            if (m_en[b]) begin
                check(ram_rd && !rom_rd && ram_addr == ra, {req, " R3 ram strobe/addr"}, ram_addr, ra);
                check(cpu_rdata == exp_ram[ra], {req, " R7 ram data"}, cpu_rdata, exp_ram[ra]);
            end else begin
                check(!ram_rd && !rom_rd && cpu_rdata == 8'h00, {req, " R7 disabled"}, cpu_rdata, 0);
            end
        end else begin
            check(rom_rd && !ram_rd && rom_addr == {m_idx[s][3:0], a[11:0]}, {req, " R2 rom addr"},
                  rom_addr, {m_idx[s][3:0], a[11:0]});
            check(rom_addr[11:0] == a[11:0], {req, " R1 offset"}, rom_addr[11:0], a[11:0]);
            check(cpu_rdata == rom_byte({m_idx[s][3:0], a[11:0]}), {req, " R2 rom data"},
                  cpu_rdata, rom_byte({m_idx[s][3:0], a[11:0]}));
        end
        @(negedge clk);
        cpu_rd = 0;
    endtask

    task automatic wr_access(input logic [15:0] a, input logic [7:0] d, input string req);
        int s; logic [1:0] b; bit go;
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1; cpu_rd = 0; cpu_wdata = d;
        #1;
        s  = a[15:12];
        b  = m_idx[s][1:0];
        go = m_ram[s] && m_en[b] && m_wr[b];
        check(ram_wr == go, {req, " R8 write gate"}, ram_wr, go);
        if (go) begin
            check(ram_addr == {b, a[11:0]} && ram_wdata == d, {req, " R8 write addr/data"},
                  ram_addr, {b, a[11:0]});
            exp_ram[{b, a[11:0]}] = d;
        end
        @(negedge clk);
        cpu_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 0;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 16384; i++) begin ram_mem[i] = 8'h00; exp_ram[i] = 8'h00; end
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 reset map
        rd_check(16'h8123, "R11 slot8");
        rd_check(16'hF0A5, "R11 slotF");
        rd_check(16'h0010, "R11 slot0");
        wr_access(16'h7456, 8'hA7, "R11 slot7");
        rd_check(16'h7456, "R11 slot7 readback");
        wr_access(16'h9000, 8'h11, "R8 rom write dropped");
        rd_check(16'h9000, "R8 rom after write");

        // R3: index beyond bank counts
        send(3'd1, 2'd0, 4'd9, 8'h35, 0);
        rd_check(16'h9ABC, "R3 rom mask");
        send(3'd1, 2'd0, 4'd4, 8'h36, 0);
        wr_access(16'h4001, 8'h5D, "R3 ram mask");
        rd_check(16'h4001, "R3 ram mask rb");

        // R4 sizes
        send(3'd1, 2'd1, 4'd10, 8'h03, 0);
        rd_check(16'hA000, "R4 8k lo");
        rd_check(16'hB000, "R4 8k hi");
        send(3'd1, 2'd3, 4'd8, 8'h01, 0);
        rd_check(16'hC777, "R4 32k");

        // R5 run past slot 15
        send(3'd1, 2'd3, 4'd12, 8'h02, 0);
        rd_check(16'hF001, "R5 top slot");
        rd_check(16'h0002, "R5 slot0 untouched");
        send(3'd2, 2'd2, 4'd14, 8'h00, 1);
        rd_check(16'hE003, "R5 kind top");
        rd_check(16'h0004, "R5 kind slot0 untouched");
        send(3'd2, 2'd2, 4'd14, 8'h00, 0);

        // R6 kind
        send(3'd2, 2'd1, 4'd0, 8'h00, 1);
        wr_access(16'h1234, 8'hC3, "R6 ram slot1");
        rd_check(16'h1234, "R6 ram slot1 rb");

        // R12: command and access in the same cycle
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_size = 2'd0; cmd_slot = 4'd8; cmd_index = 8'h0B; cmd_flag = 0;
        cpu_addr = 16'h8040; cpu_rd = 1;
        #1;
        check(rom_addr == {4'(m_idx[8]), 12'h040}, "R12 old map same cycle", rom_addr, {4'(m_idx[8]), 12'h040});
        @(negedge clk);
        cmd_valid = 0;
        model_cmd(3'd1, 2'd0, 4'd8, 8'h0B, 0);
        #1;
        check(rom_addr == 16'hB040, "R12 new map next cycle", rom_addr, 16'hB040);
        @(negedge clk);
        cpu_rd = 0;

        // R9 global enable / write-permit
        send(3'd4, 2'd0, 4'd0, 8'h00, 0);
        wr_access(16'h5010, 8'hEE, "R9 wp all");
        rd_check(16'h5010, "R9 wp all rb");
        send(3'd3, 2'd0, 4'd0, 8'h00, 0);
        rd_check(16'h5010, "R9 disabled all");
        send(3'd3, 2'd0, 4'd0, 8'h00, 1);
        send(3'd4, 2'd0, 4'd0, 8'h00, 1);

        // R10 single bank, and reserved opcodes
        send(3'd5, 2'd0, 4'd0, 8'h05, 0);
        rd_check(16'h5222, "R10 bank1 disabled");
        rd_check(16'h6222, "R10 bank2 enabled");
        send(3'd6, 2'd0, 4'd0, 8'h02, 0);
        wr_access(16'h6333, 8'h77, "R10 bank2 protected");
        send(3'd7, 2'd3, 4'd0, 8'h00, 1);
        send(3'd0, 2'd3, 4'd0, 8'h00, 1);
        rd_check(16'h5222, "R10 nop keeps");
        rd_check(16'h0100, "R10 nop keeps slot0");

        // constrained random
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom % 10;
            if (r < 3)
                send(3'($urandom % 8), 2'($urandom), 4'($urandom), 8'($urandom), 1'($urandom));
            else if (r < 6)
                wr_access(16'($urandom), 8'($urandom), "R8 random write");
            else
                rd_check(16'($urandom), "R2 random read");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule